// File: doc/BRIEF.md
# Serial Programming Port Target Responder

This block is the target end of a two-wire serial programming link, built as synthesizable logic so that a host-side programming sequencer can be run against it in loopback. The host toggles a port clock and drives a data line. Each transfer, called a frame, is a 4-bit command followed by a 16-bit payload, both sent least significant bit first. The responder watches the port clock after synchronising it into its own system clock. It recognises the few core-instruction payloads that set up a 22-bit read pointer, and it answers read-with-post-increment commands with a byte from a small internal memory.

Setting the pointer takes pairs of instructions. A literal-load payload places a byte in a working register. A copy payload then moves that register into the upper, high or low byte of the pointer. A read command takes the addressed byte partway through the payload. The responder turns the shared data line into an output after the eighth payload clock, shifts the byte out over the last eight payload clocks, releases the line when the frame ends, and advances the pointer. Any other payload or command leaves the state unchanged.

Top module: `prog_port_target`

## Requirements
- R1: After reset the data output enable and the data output are 0, and the pointer and working register are 0. A read issued first therefore returns the byte at address 0. A reset in the middle of a frame restarts the frame count.
- R2: On each falling edge of the port clock, as seen through the two-flop synchroniser, one data bit is taken. The first 4 bits of a frame form the command, least significant bit first. The next 16 bits form the payload, least significant bit first. Each port clock level must last at least 4 system clocks.
- R3: Under command 4'b0000, a payload of 16'h0Exx loads xx into the working register.
- R4: Under command 4'b0000, payload 16'h6EF8 copies working register bits [5:0] into pointer bits [21:16]. Payload 16'h6EF7 copies the register into bits [15:8], and 16'h6EF6 copies it into bits [7:0].
- R5: Other payloads under 4'b0000 have no effect, and commands other than 4'b0000 and 4'b1001 have no effect. No effect means the pointer and working register keep their values and the output enable stays 0.
- R6: Under command 4'b1001, the byte at the pointer is shifted out least significant bit first. Bit k is driven after the rising edge of payload clock 9+k and is valid at that clock's falling edge.
- R7: The output enable rises after the falling edge of payload clock 8 of a read frame and falls after the falling edge of payload clock 16. It is 0 in every other frame.
- R8: Each read frame adds one to the pointer as it ends, wrapping from 22'h3FFFFF to 0.
- R9: Address a below the memory depth (default 64) holds a[7:0] XOR 8'hA5. Every other address reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_in | input | 1 | Port clock from the host, asynchronous |
| pdat_in | input | 1 | Data line as driven by the host |
| pdat_out | output | 1 | Data line value driven by the responder |
| pdat_oe | output | 1 | High while the responder drives the data line |

## Verification
Pointers are set up inside the memory, on its last location, on the first location past it, far outside it and at the top of the 22-bit space. A second read after each first read tells the increment apart from a reload, and it shows the step across the memory edge and the wrap to zero. The enable is sampled just before clock 8 falls, through the shift window and after the frame ends, which tells an early or late turnaround apart from a correct one. Directed frames send near-miss payloads, a non-core command carrying a copy payload and a reset in mid-frame. These separate ignored input from input that was acted on.

// File: rtl/prog_port_pkg.sv
package prog_port_pkg;
  localparam int CMD_W = 4;
  localparam int PAY_W = 16;
  localparam int PTR_W = 22;
  localparam int FRAME = CMD_W + PAY_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_CORE  = 4'b0000,
    CMD_RD_PI = 4'b1001
  } cmd_e;

  localparam logic [7:0] OP_LIT  = 8'h0E;
  localparam logic [7:0] OP_MOVE = 8'h6E;
  localparam logic [7:0] SEL_UPR = 8'hF8;
  localparam logic [7:0] SEL_HI  = 8'hF7;
  localparam logic [7:0] SEL_LO  = 8'hF6;
endpackage

// File: rtl/prog_port_sync.sv
module prog_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pclk_a,
  input  logic pdat_a,
  output logic srst_n,
  output logic pclk_rise,
  output logic pclk_fall,
  output logic pdat_s
);
  logic [1:0]        rst_q;
  logic [STAGES:0]   cpipe_q, cpipe_n;
  logic [STAGES-1:0] dpipe_q, dpipe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  generate
    if (STAGES > 1) begin : g_multi
      always_comb begin
        cpipe_n = {cpipe_q[STAGES-1:0], pclk_a};
        dpipe_n = {dpipe_q[STAGES-2:0], pdat_a};
      end
    end else begin : g_single
      always_comb begin
        cpipe_n = {cpipe_q[STAGES-1:0], pclk_a};
        dpipe_n = pdat_a;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cpipe_q <= '0;
      dpipe_q <= '0;
    end else begin
      cpipe_q <= cpipe_n;
      dpipe_q <= dpipe_n;
    end
  end

  assign pclk_rise = cpipe_q[STAGES-1] & ~cpipe_q[STAGES];
  assign pclk_fall = ~cpipe_q[STAGES-1] & cpipe_q[STAGES];
  assign pdat_s    = dpipe_q[STAGES-1];
endmodule

// File: rtl/prog_port_rom.sv
module prog_port_rom
  import prog_port_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic [PTR_W-1:0] addr,
  output logic [7:0]       data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

  logic [7:0] tbl [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [7:0] CONTENT = 8'(i) ^ 8'hA5;
      assign tbl[i] = CONTENT;
    end
  endgenerate

  always_comb begin
    if (addr < LIMIT) data = tbl[addr[AW-1:0]];
    else              data = 8'hFF;
  end
endmodule

// File: rtl/prog_port_engine.sv
module prog_port_engine
  import prog_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_rise,
  input  logic             pclk_fall,
  input  logic             din,
  input  logic [7:0]       rdata,
  output logic [PTR_W-1:0] ptr,
  output logic             dout,
  output logic             oe
);
  localparam int CW = $clog2(FRAME);
  localparam logic [CW-1:0] CNT_LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] CNT_OE   = CW'(CMD_W + 7);
  localparam logic [CW-1:0] CNT_CMD  = CW'(CMD_W);

  logic [CW-1:0]    cnt_q, cnt_n;
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic [PAY_W-1:0] pay_q, pay_n, pay_sh;
  logic [7:0]       w_q, w_n;
  logic [7:0]       rsh_q, rsh_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             oe_q, oe_n, dout_q, dout_n;

  always_comb begin
    cnt_n  = cnt_q;
    cmd_n  = cmd_q;
    pay_n  = pay_q;
    w_n    = w_q;
    rsh_n  = rsh_q;
    ptr_n  = ptr_q;
    oe_n   = oe_q;
    dout_n = dout_q;
    pay_sh = {din, pay_q[PAY_W-1:1]};

    if (pclk_fall) begin
      if (cnt_q < CNT_CMD) cmd_n = {din, cmd_q[CMD_W-1:1]};
      else                 pay_n = pay_sh;
      cnt_n = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;

      if (cnt_q == CNT_OE && cmd_q == CMD_RD_PI) begin
        oe_n  = 1'b1;
        rsh_n = rdata;
      end

      if (cnt_q == CNT_LAST) begin
        oe_n = 1'b0;
        if (cmd_q == CMD_RD_PI) begin
          ptr_n = ptr_q + 1'b1;
        end else if (cmd_q == CMD_CORE) begin
          if (pay_sh[15:8] == OP_LIT) begin
            w_n = pay_sh[7:0];
          end else if (pay_sh[15:8] == OP_MOVE) begin
            case (pay_sh[7:0])
              SEL_UPR: ptr_n[PTR_W-1:16] = w_q[PTR_W-17:0];
              SEL_HI:  ptr_n[15:8]       = w_q;
              SEL_LO:  ptr_n[7:0]        = w_q;
              default: ;
            endcase
          end
        end
      end
    end

    if (pclk_rise && oe_q) begin
      dout_n = rsh_q[0];
      rsh_n  = {1'b1, rsh_q[7:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      pay_q  <= '0;
      w_q    <= '0;
      rsh_q  <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      cmd_q  <= cmd_n;
      pay_q  <= pay_n;
      w_q    <= w_n;
      rsh_q  <= rsh_n;
      ptr_q  <= ptr_n;
      oe_q   <= oe_n;
      dout_q <= dout_n;
    end
  end

  assign ptr  = ptr_q;
  assign dout = dout_q;
  assign oe   = oe_q;
endmodule

// File: rtl/prog_port_target.sv
module prog_port_target
  import prog_port_pkg::*;
#(
  parameter int MEM_DEPTH   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pclk_in,
  input  logic pdat_in,
  output logic pdat_out,
  output logic pdat_oe
);
  logic             srst_n;
  logic             pclk_rise, pclk_fall, pdat_s;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rdata;

  prog_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_a    (pclk_in),
    .pdat_a    (pdat_in),
    .srst_n    (srst_n),
    .pclk_rise (pclk_rise),
    .pclk_fall (pclk_fall),
    .pdat_s    (pdat_s)
  );

  prog_port_rom #(.DEPTH(MEM_DEPTH)) u_rom (
    .addr (ptr),
    .data (rdata)
  );

  prog_port_engine u_eng (
    .clk       (clk),
    .rst_n     (srst_n),
    .pclk_rise (pclk_rise),
    .pclk_fall (pclk_fall),
    .din       (pdat_s),
    .rdata     (rdata),
    .ptr       (ptr),
    .dout      (pdat_out),
    .oe        (pdat_oe)
  );
endmodule

// File: rtl/prog_port_chk.sv
module prog_port_chk
  import prog_port_pkg::*;
(
  input logic             clk,
  input logic             srst_n,
  input logic             fall,
  input logic             rise,
  input logic             din,
  input logic [PTR_W-1:0] ptr,
  input logic             oe,
  input logic             dout
);
  logic [4:0] k;
  logic [3:0] c;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      k <= '0;
      c <= '0;
    end else if (fall) begin
      k <= (k == 5'd19) ? 5'd0 : k + 5'd1;
      if (k < 5'd4) c <= {din, c[3:1]};
    end
  end

  // R7: enable rises only at the 8th payload falling edge of a read frame
  assert_oe_rise_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(oe) |-> $past(fall && k == 5'd11 && c == 4'b1001));

  // R7: enable drops only as the frame ends
  assert_oe_fall_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(oe) |-> $past(fall && k == 5'd19));

  // R8: a completed read frame advances the pointer by one
  assert_ptr_inc_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (fall && k == 5'd19 && c == 4'b1001) |=> ptr == $past(ptr) + 22'd1);

  // R5: pointer never moves except at the end of a frame
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(ptr) |-> $past(fall && k == 5'd19));

  // R6: output bit changes only on a rising port edge while driving
  assert_dout_edge_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(dout) |-> $past(rise && oe));
endmodule

bind prog_port_target prog_port_chk u_chk (
  .clk    (clk),
  .srst_n (srst_n),
  .fall   (pclk_fall),
  .rise   (pclk_rise),
  .din    (pdat_s),
  .ptr    (ptr),
  .oe     (pdat_oe),
  .dout   (pdat_out)
);

// File: tb/prog_port_target_bench.sv
module prog_port_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pclk_in = 1'b0;
  logic pdat_in = 1'b0;
  logic pdat_out, pdat_oe;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  prog_port_target u_prog_port_target (
    .clk(clk), .rst_n(rst_n), .pclk_in(pclk_in), .pdat_in(pdat_in),
    .pdat_out(pdat_out), .pdat_oe(pdat_oe)
  );

  // {address, expected first read, expected second read}
  localparam int NV = 7;
  localparam logic [37:0] VEC [NV] = '{
    {22'h000000, 8'hA5, 8'hA4},
    {22'h000005, 8'hA0, 8'hA3},
    {22'h00003F, 8'h9A, 8'hFF},
    {22'h000040, 8'hFF, 8'hFF},
    {22'h3FFFFF, 8'hFF, 8'hA5},
    {22'h012345, 8'hFF, 8'hFF},
    {22'h000020, 8'h85, 8'h84}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    pdat_in = b;
    wait_n(2);
    pclk_in = 1'b1;
    wait_n(8);
    pclk_in = 1'b0;
    wait_n(8);
  endtask

  task automatic send(input logic [3:0] cmd, input logic [15:0] pay);
    for (int i = 0; i < 4; i++) clk_bit(cmd[i]);
    for (int i = 0; i < 16; i++) clk_bit(pay[i]);
  endtask

  task automatic set_ptr(input logic [21:0] a);
    send(4'b0000, {8'h0E, 2'b00, a[21:16]});
    send(4'b0000, 16'h6EF8);
    send(4'b0000, {8'h0E, a[15:8]});
    send(4'b0000, 16'h6EF7);
    send(4'b0000, {8'h0E, a[7:0]});
    send(4'b0000, 16'h6EF6);
  endtask

  task automatic read_byte(output logic [7:0] d, output logic oe_pre,
                           output logic oe_mid, output logic oe_post);
    logic [3:0] rc = 4'b1001;
    for (int i = 0; i < 4; i++) clk_bit(rc[i]);
    oe_mid = 1'b1;
    for (int p = 1; p <= 16; p++) begin
      pdat_in = 1'b0;
      wait_n(2);
      pclk_in = 1'b1;
      wait_n(8);
      if (p == 8) oe_pre = pdat_oe;
      if (p >= 9) begin
        d[p-9] = pdat_out;
        oe_mid = oe_mid & pdat_oe;
      end
      pclk_in = 1'b0;
      wait_n(8);
      if (p >= 8 && p < 16) oe_mid = oe_mid & pdat_oe;
    end
    oe_post = pdat_oe;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic op, om, oq;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check("R1 oe after reset", 32'(pdat_oe), 32'd0);
    check("R1 dout after reset", 32'(pdat_out), 32'd0);
    read_byte(d, op, om, oq);
    check("R1 first read from address 0", 32'(d), 32'hA5);

    for (int v = 0; v < NV; v++) begin
      set_ptr(VEC[v][37:16]);
      read_byte(d, op, om, oq);
      check("R2 R3 R4 R6 R9 read data", 32'(d), 32'(VEC[v][15:8]));
      check("R7 oe low before clock 8 falls", 32'(op), 32'd0);
      check("R7 oe high during shift", 32'(om), 32'd1);
      check("R7 oe released after frame", 32'(oq), 32'd0);
      read_byte(d, op, om, oq);
      check("R8 R9 read after increment", 32'(d), 32'(VEC[v][7:0]));
    end

    // R5: near-miss payloads and a foreign command leave the pointer alone
    set_ptr(22'h000005);
    send(4'b0000, 16'h0E33);
    send(4'b0000, 16'h6EF9);
    send(4'b0000, 16'h6FF6);
    send(4'b0000, 16'h1234);
    send(4'b0010, 16'h6EF6);
    check("R5 oe stays low for ignored frames", 32'(pdat_oe), 32'd0);
    read_byte(d, op, om, oq);
    check("R5 pointer unchanged by ignored payloads", 32'(d), 32'hA0);
    send(4'b0000, 16'h6EF6);
    read_byte(d, op, om, oq);
    check("R3 R4 working register copied to low byte", 32'(d), 32'h96);

    // R5: a command that is not a read does not drive the line
    for (int i = 0; i < 4; i++) clk_bit(i == 1 ? 1'b1 : 1'b0);
    for (int p = 0; p < 12; p++) clk_bit(1'b0);
    check("R5 oe low in non-read frame", 32'(pdat_oe), 32'd0);
    for (int p = 0; p < 4; p++) clk_bit(1'b0);

    // R1: reset in mid-frame restarts the frame and the pointer
    for (int i = 0; i < 7; i++) clk_bit(1'b1);
    rst_n = 1'b0;
    wait_n(4);
    check("R1 oe low in reset", 32'(pdat_oe), 32'd0);
    rst_n = 1'b1;
    wait_n(5);
    read_byte(d, op, om, oq);
    check("R1 read after mid-frame reset", 32'(d), 32'hA5);
    check("R1 R7 oe turnaround after reset", 32'({op, om, oq}), 32'b010);

    finish_run();
  end
endmodule